// File: doc/BRIEF.md
# Assignable Priority Interrupt Controller

This block gathers seventeen interrupt sources for a processor core and presents the single highest-priority pending, enabled source as a registered request plus a 5-bit vector index. Five sources are fixed: reset, emulator, power-down, emulator kernel and stack. The other twelve are user levels. Each peripheral request line is steered to one user level through a writable assignment table, so software sets a peripheral's service priority by the level it chooses for that peripheral.

User levels are edge-triggered. A rising edge on a level's combined line sets a pending latch, and an acknowledge naming that level's vector clears it. Fixed sources are level-sensitive. A per-vector enable mask and a global enable gate every source except reset and emulator. Everything after the vector index (vectoring, stacking) belongs to the core.

Top module: `irqc_top`

## Requirements
- R1: After reset `irq` is 0 and `irq_vec` is 0, no user level is pending, and every peripheral is unassigned.
- R2: Vector indices are fixed: reset 0, emulator 1, power-down 2, emulator kernel 3, stack 4, and user level k is 5+k. Among the pending, enabled sources, the lowest index wins.
- R3: A clock edge with `asg_we` high maps peripheral `asg_sel` to level `asg_lvl` from the next cycle on. A level code of 12 or more leaves the peripheral unassigned, and its requests are then ignored.
- R4: A user level's latch sets on a rising edge of that level's line. It stays set after the line falls, until it is acknowledged.
- R5: An edge with `ack` high and `ack_vec` = 5+k clears latch k. A rising edge on level k in the same cycle takes precedence and leaves the latch set. An acknowledge naming a fixed vector has no effect.
- R6: Fixed sources are pending exactly while their bit of `fixed_req` is high. Bit i of `fixed_req` is vector i.
- R7: For vectors 2 to 16, a source can win only when its `mask` bit is 1 and `gie` is 1. Vectors 0 and 1 ignore `mask` and `gie`. A gated latch stays pending and wins once it is enabled again.
- R8: `irq` and `irq_vec` are registered and show the selection made from the state and inputs of the previous cycle. `irq_vec` is 0 whenever `irq` is 0.
- R9: A level's line is the OR of all peripherals mapped to it. When a second mapped peripheral rises while another is already high, no new edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | 16 | Peripheral request lines |
| fixed_req | input | 5 | Fixed source lines; bit i is vector i |
| asg_we | input | 1 | Assignment table write strobe |
| asg_sel | input | 4 | Peripheral to reassign |
| asg_lvl | input | 4 | New user level; 12 to 15 means unassigned |
| mask | input | 17 | Per-vector enable; bit v is vector v |
| gie | input | 1 | Global enable |
| ack | input | 1 | Acknowledge strobe |
| ack_vec | input | 5 | Vector being acknowledged |
| irq | output | 1 | Registered interrupt request |
| irq_vec | output | 5 | Registered winning vector index |

## Verification
The bench builds the block with its default parameters: sixteen peripherals and twelve user levels, which gives the full seventeen-vector space. With these values every user level can be targeted, including the lowest-priority level at vector 16. There are also enough spare peripherals to map several onto one level and leave others unassigned. Directed scenarios cover the fixed-priority chain, acknowledge racing a new edge, masking while pending, and OR-merged lines. A long randomized phase follows, with reassignment running during traffic, and a behavioural model is compared with the outputs on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int FIXED_CNT   = 5;
    localparam int VEC_RESET   = 0;
    localparam int VEC_EMU     = 1;
    localparam int VEC_PWDN    = 2;
    localparam int VEC_KERNEL  = 3;
    localparam int VEC_STACK   = 4;
    localparam int UNGATED_CNT = 2;
endpackage

// File: rtl/irqc_level_map.sv
module irqc_level_map #(
    parameter int NP    = 16,
    parameter int NL    = 12,
    parameter int LVL_W = 4,
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PER_W-1:0] wr_sel,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic [NP-1:0]    periph_req,
    output logic [NL-1:0]    lvl_line
);
    logic [LVL_W-1:0] asg_q [NP];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) asg_q[p] <= '1;
        end else if (wr_en && (int'(wr_sel) < NP)) begin
            asg_q[wr_sel] <= wr_lvl;
        end
    end

    for (genvar k = 0; k < NL; k++) begin : g_lvl
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int p = 0; p < NP; p++)
                if (asg_q[p] == LVL_W'(k)) hit = hit | periph_req[p];
        end
        assign lvl_line[k] = hit;
    end

    // R3: a write lands in the table on the next cycle
    p_map_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_sel) < NP) |=> asg_q[$past(wr_sel)] == $past(wr_lvl));
endmodule

// File: rtl/irqc_level_latch.sv
module irqc_level_latch #(
    parameter int NL = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] line,
    input  logic [NL-1:0] clr,
    output logic [NL-1:0] lat
);
    logic [NL-1:0] line_q;
    logic [NL-1:0] rise;

    assign rise = line & ~line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            lat    <= '0;
        end else begin
            line_q <= line;
            lat    <= (lat & ~clr) | rise;
        end
    end

    // R4: a rising edge always leaves its latch set
    p_edge_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> (lat & $past(rise)) == $past(rise));
    // R4: without a clear, pending bits are held
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> (lat & $past(lat)) == $past(lat));
    // R5: a clear without a competing edge empties the latch
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~rise) != '0) |=> (lat & $past(clr & ~rise)) == '0);
endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel
    import irqc_pkg::*;
#(
    parameter int NV = 17,
    parameter int VW = 5
) (
    input  logic [NV-1:0] req,
    input  logic [NV-1:0] mask,
    input  logic          gie,
    output logic          found,
    output logic [VW-1:0] win
);
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int v = NV - 1; v >= 0; v--) begin
            if (req[v] && (v < UNGATED_CNT || (mask[v] && gie))) begin
                found = 1'b1;
                win   = VW'(v);
            end
        end
    end

    always_comb begin
        // R2: the winner is a pending source
        p_win_pending_r2: assert (!found || req[win]);
        // R7: global disable leaves only reset and emulator eligible
        p_gie_block_r7: assert (gie || !found || int'(win) < UNGATED_CNT);
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_PERIPH = 16,
    parameter int NUM_LEVELS = 12,
    localparam int NUM_VEC   = FIXED_CNT + NUM_LEVELS,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int LVL_W     = $clog2(NUM_LEVELS + 1),
    localparam int PER_W     = $clog2(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic [FIXED_CNT-1:0]  fixed_req,
    input  logic                  asg_we,
    input  logic [PER_W-1:0]      asg_sel,
    input  logic [LVL_W-1:0]      asg_lvl,
    input  logic [NUM_VEC-1:0]    mask,
    input  logic                  gie,
    input  logic                  ack,
    input  logic [VEC_W-1:0]      ack_vec,
    output logic                  irq,
    output logic [VEC_W-1:0]      irq_vec
);
    logic [NUM_LEVELS-1:0] lvl_line;
    logic [NUM_LEVELS-1:0] lvl_clr;
    logic [NUM_LEVELS-1:0] lvl_pend;
    logic [NUM_VEC-1:0]    all_req;
    logic                  sel_found;
    logic [VEC_W-1:0]      sel_win;

    irqc_level_map #(.NP(NUM_PERIPH), .NL(NUM_LEVELS), .LVL_W(LVL_W), .PER_W(PER_W)) i_map (
        .clk(clk), .rst_n(rst_n), .wr_en(asg_we), .wr_sel(asg_sel), .wr_lvl(asg_lvl),
        .periph_req(periph_req), .lvl_line(lvl_line)
    );

    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_clr
        assign lvl_clr[k] = ack && (ack_vec == VEC_W'(FIXED_CNT + k));
    end

    irqc_level_latch #(.NL(NUM_LEVELS)) i_latch (
        .clk(clk), .rst_n(rst_n), .line(lvl_line), .clr(lvl_clr), .lat(lvl_pend)
    );

    assign all_req = {lvl_pend, fixed_req};

    irqc_prio_sel #(.NV(NUM_VEC), .VW(VEC_W)) i_sel (
        .req(all_req), .mask(mask), .gie(gie), .found(sel_found), .win(sel_win)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq     <= sel_found;
            irq_vec <= sel_win;
        end
    end

    // R8: idle vector reads zero
    p_idle_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> irq_vec == '0);
    // R2: reset source always wins on the following cycle
    p_reset_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_req[VEC_RESET] |=> (irq && irq_vec == VEC_W'(VEC_RESET)));
    // R7: emulator ignores mask and global enable
    p_emu_ungated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_req[VEC_EMU] && !fixed_req[VEC_RESET]) |=> (irq && irq_vec == VEC_W'(VEC_EMU)));
endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;
    localparam int NP = 16;
    localparam int NL = 12;
    localparam int NF = 5;
    localparam int NV = NF + NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] periph_req = '0;
    logic [NF-1:0] fixed_req = '0;
    logic          asg_we = 1'b0;
    logic [3:0]    asg_sel = '0;
    logic [3:0]    asg_lvl = '0;
    logic [NV-1:0] mask = '0;
    logic          gie = 1'b0;
    logic          ack = 1'b0;
    logic [4:0]    ack_vec = '0;
    logic          irq;
    logic [4:0]    irq_vec;

    always #2.5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .fixed_req(fixed_req),
        .asg_we(asg_we), .asg_sel(asg_sel), .asg_lvl(asg_lvl), .mask(mask), .gie(gie),
        .ack(ack), .ack_vec(ack_vec), .irq(irq), .irq_vec(irq_vec)
    );

    int errors = 0;
    int checks = 0;

    // behavioural reference
    int m_asg [NP];
    bit m_lat [NL];
    bit m_line_q [NL];
    bit m_irq;
    int m_vec;

    task automatic model_reset();
        for (int p = 0; p < NP; p++) m_asg[p] = 15;
        for (int k = 0; k < NL; k++) begin m_lat[k] = 0; m_line_q[k] = 0; end
        m_irq = 0; m_vec = 0;
    endtask

    task automatic model_step();
        bit line [NL];
        bit found;
        int w;
        for (int k = 0; k < NL; k++) begin
            line[k] = 0;
            for (int p = 0; p < NP; p++) if (m_asg[p] == k && periph_req[p]) line[k] = 1;
        end
        found = 0; w = 0;
        for (int v = 0; v < NV; v++) begin
            bit pend, en;
            pend = (v < NF) ? fixed_req[v] : m_lat[v - NF];
            en   = (v < 2) || (mask[v] && gie);
            if (!found && pend && en) begin found = 1; w = v; end
        end
        m_irq = found; m_vec = w;
        for (int k = 0; k < NL; k++) begin
            if (ack && int'(ack_vec) == NF + k) m_lat[k] = 0;
            if (line[k] && !m_line_q[k]) m_lat[k] = 1;
            m_line_q[k] = line[k];
        end
        if (asg_we) m_asg[asg_sel] = int'(asg_lvl);
    endtask

    task automatic check(input string tag, input bit a_irq, input int a_vec, input bit e_irq, input int e_vec);
        checks++;
        if (a_irq !== e_irq || a_vec != e_vec) begin
            errors++;
            $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d at %0t", tag, a_irq, a_vec, e_irq, e_vec, $time);
        end
    endtask

    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, irq, int'(irq_vec), m_irq, m_vec);
    endtask

    task automatic assign_p(input int p, input int lvl, input string tag);
        asg_we = 1; asg_sel = 4'(p); asg_lvl = 4'(lvl);
        tick(tag);
        asg_we = 0;
    endtask

    task automatic do_ack(input int v, input string tag);
        ack = 1; ack_vec = 5'(v);
        tick(tag);
        ack = 0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset state", irq, int'(irq_vec), 0, 0);
        mask = '1; gie = 1;
        tick("R1");

        // R6 / R2: fixed chain
        fixed_req = 5'b11111; tick("R6"); tick("R2 reset first");
        fixed_req = 5'b11110; tick("R2 emu");
        fixed_req = 5'b11100; tick("R2 pwdn");
        fixed_req = 5'b11000; tick("R2 kernel");
        fixed_req = 5'b10000; tick("R2 stack");
        fixed_req = 5'b00000; tick("R6 released"); tick("R8 idle");

        // R3 unassigned peripheral ignored
        periph_req[3] = 1; tick("R3 unassigned"); periph_req[3] = 0; tick("R3 unassigned");
        tick("R3 no pending");
        // R3 / R4 assignment then pulse
        assign_p(3, 2, "R3 write");
        periph_req[3] = 1; tick("R4 edge"); periph_req[3] = 0; tick("R4 held"); tick("R4 held");
        do_ack(7, "R5 ack"); tick("R5 cleared");
        // R5 ack on fixed vector does nothing
        periph_req[3] = 1; tick("R4"); periph_req[3] = 0; tick("R4");
        do_ack(2, "R5 fixed ack ignored"); tick("R5 still pending");
        // R5 ack races a new edge
        ack = 1; ack_vec = 7; tick("R5 race pre");
        ack = 0; periph_req[3] = 1; ack = 1; tick("R5 race"); ack = 0; periph_req[3] = 0;
        tick("R5 edge wins"); do_ack(7, "R5"); tick("R5");

        // R2 user levels: 0 beats 11
        assign_p(0, 11, "R3"); assign_p(1, 0, "R3");
        periph_req[1:0] = 2'b11; tick("R2 users"); periph_req[1:0] = 0; tick("R2 level0 first");
        do_ack(5, "R2 ack level0"); tick("R2 level11 next"); do_ack(16, "R2"); tick("R2 empty");
        // R3 reassign to unassigned code
        assign_p(1, 13, "R3 unassign"); periph_req[1] = 1; tick("R3"); periph_req[1] = 0; tick("R3 ignored");

        // R7 masking
        periph_req[0] = 1; mask[16] = 0; tick("R7 masked"); periph_req[0] = 0; tick("R7 masked held");
        tick("R7"); mask[16] = 1; tick("R7 unmasked"); tick("R7 wins");
        gie = 0; tick("R7 gie off"); tick("R7 gated");
        fixed_req = 5'b00100; tick("R7 pwdn gated"); tick("R7");
        fixed_req = 5'b00010; tick("R7 emu ungated"); tick("R7");
        fixed_req = 5'b00001; mask[0] = 0; tick("R7 reset ungated"); tick("R7");
        fixed_req = 0; mask = '1; gie = 1; tick("R7"); do_ack(16, "R7"); tick("R7");

        // R9 OR merge
        assign_p(4, 3, "R9"); assign_p(5, 3, "R9");
        periph_req[4] = 1; tick("R9 first"); tick("R9");
        do_ack(8, "R9 ack"); tick("R9");
        periph_req[5] = 1; tick("R9 no new edge"); tick("R9 no new edge");
        periph_req[4] = 0; periph_req[5] = 0; tick("R9"); periph_req[5] = 1; tick("R9 new edge");
        periph_req[5] = 0; tick("R9"); do_ack(8, "R9"); tick("R9");

        // randomized traffic
        for (int i = 0; i < 3000; i++) begin
            periph_req = NP'($urandom);
            fixed_req  = ($urandom_range(0, 9) == 0) ? NF'($urandom) & 5'b11100 : '0;
            if ($urandom_range(0, 40) == 0) fixed_req[$urandom_range(0, 1)] = 1;
            mask    = ($urandom_range(0, 7) == 0) ? NV'($urandom) : '1;
            gie     = ($urandom_range(0, 15) != 0);
            asg_we  = ($urandom_range(0, 5) == 0);
            asg_sel = 4'($urandom); asg_lvl = 4'($urandom);
            ack     = ($urandom_range(0, 2) == 0);
            ack_vec = irq ? irq_vec : 5'($urandom_range(0, NV - 1));
            tick("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end
        asg_we = 0; ack = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule